// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the upper eleven bits of a 32-bit instruction word into the full set of datapath control lines for a single-cycle load/store processor. It is purely combinational. The eleven-bit field (instruction bits 31:21) enters on `opc_i`. In the same cycle the block drives the ALU operand-B select, the write-back source select, the memory read and write strobes, the conditional and unconditional branch strobes, the register-file write enable, and the second-read-port register select. It also drives a 4-bit ALU operation code and a 3-bit code that selects the immediate format.

The 4-bit ALU code is derived straight from the opcode, with no narrower intermediate ALU-op stage. Nine instruction forms are recognised:

- load and store
- compare-and-branch-if-zero
- register add, subtract, AND and OR
- move-wide-with-zero
- unconditional branch

The last two are matched on shorter prefixes of the field: 9 bits for move-wide and 6 bits for the branch. Any other value decodes to a harmless no-operation that writes nothing and does not branch.

Internally, a bank of generated prefix matchers classifies the opcode into an enumerated instruction class. A single `unique case` over that class then produces every output.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 11111000010 (load) drives alu_src=1, wb_from_mem=1, mem_rd=1, reg_wr=1, mem_wr=0, br_zero=0, br_always=0, rd2_sel=0, alu_op=0010, imm_sel=111.
- R2: Opcode 11111000000 (store) drives alu_src=1, mem_wr=1, rd2_sel=1, alu_op=0010, imm_sel=111, with wb_from_mem, mem_rd, reg_wr and both branch strobes at 0.
- R3: Opcode 10110100000 (compare-and-branch-if-zero) drives br_zero=1, rd2_sel=1, alu_op=0111 (pass operand B), imm_sel=101, with every other strobe and select at 0.
- R4: Opcodes 10001011000 (add) and 11001011000 (subtract) drive reg_wr=1 and alu_op 0010 and 0110 respectively. All other strobes and selects are 0 and imm_sel=000.
- R5: Opcodes 10001010000 (AND) and 10101010000 (OR) drive reg_wr=1 and alu_op 0000 and 0001 respectively. All other strobes and selects are 0 and imm_sel=000.
- R6: Any opcode whose upper nine bits are 110100101 (move-wide-with-zero) drives alu_src=1, reg_wr=1, alu_op=0111, imm_sel=001, with all other strobes and selects at 0. This holds whatever the two low bits are.
- R7: Any opcode whose upper six bits are 000101 (unconditional branch) drives br_always=1, imm_sel=100, alu_op=0000, with all other strobes and selects at 0. This holds whatever the five low bits are.
- R8: Every other opcode value drives all strobes and selects to 0, alu_op=0000 and imm_sel=000.
- R9: At most one of mem_rd, mem_wr, br_zero and br_always is 1 for any opcode, and wb_from_mem equals mem_rd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opc_i | input | 11 | Instruction bits 31:21 |
| alu_src_o | output | 1 | ALU operand B: 1 = immediate, 0 = register |
| wb_from_mem_o | output | 1 | Write-back source: 1 = memory data, 0 = ALU result |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| br_zero_o | output | 1 | Branch taken if the ALU result is zero |
| br_always_o | output | 1 | Unconditional branch |
| reg_wr_o | output | 1 | Register file write enable |
| rd2_sel_o | output | 1 | Second read port address: 1 = bits 4:0, 0 = bits 20:16 |
| alu_op_o | output | 4 | ALU operation code |
| imm_sel_o | output | 3 | Immediate format select |

## Verification
The assertions assume only that `opc_i` carries a defined value (no X or Z bits) whenever the checker samples it. Every output is a pure function of that field, so no ordering or history between consecutive opcodes is assumed. The stimulus always drives a fully known 11-bit value: first the directed opcodes, then every one of the 2048 possible values in turn. This covers all low-bit variants of the two short-prefix forms and every unrecognised code.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

    localparam int OPC_BITS = 11;
    localparam int ALU_BITS = 4;
    localparam int IMM_BITS = 3;

    typedef enum logic [3:0] {
        CLS_NONE  = 4'd0,
        CLS_LOAD  = 4'd1,
        CLS_STORE = 4'd2,
        CLS_CBZ   = 4'd3,
        CLS_ADD   = 4'd4,
        CLS_SUB   = 4'd5,
        CLS_AND   = 4'd6,
        CLS_ORR   = 4'd7,
        CLS_MOVZ  = 4'd8,
        CLS_BR    = 4'd9
    } insn_cls_e;

    localparam int NUM_CLS = 10;

    localparam logic [ALU_BITS-1:0] ALU_AND  = 4'b0000;
    localparam logic [ALU_BITS-1:0] ALU_OR   = 4'b0001;
    localparam logic [ALU_BITS-1:0] ALU_ADD  = 4'b0010;
    localparam logic [ALU_BITS-1:0] ALU_SUB  = 4'b0110;
    localparam logic [ALU_BITS-1:0] ALU_PASS = 4'b0111;

    localparam logic [IMM_BITS-1:0] IMM_NONE = 3'b000;
    localparam logic [IMM_BITS-1:0] IMM_WIDE = 3'b001;
    localparam logic [IMM_BITS-1:0] IMM_JUMP = 3'b100;
    localparam logic [IMM_BITS-1:0] IMM_CBR  = 3'b101;
    localparam logic [IMM_BITS-1:0] IMM_MEM  = 3'b111;

    // Left-aligned match pattern for each class (low bits beyond the prefix are zero)
    function automatic logic [OPC_BITS-1:0] cls_pattern(input int idx);
        logic [OPC_BITS-1:0] p;
        p = '0;
        case (idx)
            1:       p = 11'b11111000010;
            2:       p = 11'b11111000000;
            3:       p = 11'b10110100000;
            4:       p = 11'b10001011000;
            5:       p = 11'b11001011000;
            6:       p = 11'b10001010000;
            7:       p = 11'b10101010000;
            8:       p = 11'b11010010100;
            9:       p = 11'b00010100000;
            default: p = '0;
        endcase
        return p;
    endfunction

    // Number of upper opcode bits that must match for each class
    function automatic int cls_prefix_len(input int idx);
        int n;
        case (idx)
            8:       n = 9;
            9:       n = 6;
            default: n = OPC_BITS;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ctrl_prefix_match.sv
module ctrl_prefix_match #(
    parameter int          LEN = 11,
    parameter logic [LEN-1:0] PAT = '0
) (
    input  logic [LEN-1:0] prefix_i,
    output logic           hit_o
);
    assign hit_o = (prefix_i == PAT);
endmodule

// File: rtl/ctrl_classify.sv
module ctrl_classify
    import ctrl_dec_pkg::*;
#(
    parameter int OPC_W = OPC_BITS
) (
    input  logic [OPC_W-1:0] opc_i,
    output insn_cls_e        cls_o
);
    logic [NUM_CLS-1:1] hit;

    for (genvar gi = 1; gi < NUM_CLS; gi++) begin : g_match
        localparam int               PLEN = cls_prefix_len(gi);
        localparam logic [OPC_W-1:0] FULL = cls_pattern(gi);
        ctrl_prefix_match #(
            .LEN (PLEN),
            .PAT (FULL[OPC_W-1 -: PLEN])
        ) match_i (
            .prefix_i (opc_i[OPC_W-1 -: PLEN]),
            .hit_o    (hit[gi])
        );
    end

    // Patterns are disjoint, so at most one hit is set
    always_comb begin
        cls_o = CLS_NONE;
        for (int k = 1; k < NUM_CLS; k++) begin
            if (hit[k]) cls_o = insn_cls_e'(k);
        end
    end
endmodule

// File: rtl/ctrl_table.sv
module ctrl_table
    import ctrl_dec_pkg::*;
#(
    parameter int ALU_W = ALU_BITS,
    parameter int IMM_W = IMM_BITS
) (
    input  insn_cls_e        cls_i,
    output logic             alu_src_o,
    output logic             wb_from_mem_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             br_zero_o,
    output logic             br_always_o,
    output logic             reg_wr_o,
    output logic             rd2_sel_o,
    output logic [ALU_W-1:0] alu_op_o,
    output logic [IMM_W-1:0] imm_sel_o
);
    always_comb begin
        alu_src_o     = 1'b0;
        wb_from_mem_o = 1'b0;
        mem_rd_o      = 1'b0;
        mem_wr_o      = 1'b0;
        br_zero_o     = 1'b0;
        br_always_o   = 1'b0;
        reg_wr_o      = 1'b0;
        rd2_sel_o     = 1'b0;
        alu_op_o      = ALU_AND;
        imm_sel_o     = IMM_NONE;
        unique case (cls_i)
            CLS_LOAD: begin
                alu_src_o     = 1'b1;
                wb_from_mem_o = 1'b1;
                mem_rd_o      = 1'b1;
                reg_wr_o      = 1'b1;
                alu_op_o      = ALU_ADD;
                imm_sel_o     = IMM_MEM;
            end
            CLS_STORE: begin
                alu_src_o = 1'b1;
                mem_wr_o  = 1'b1;
                rd2_sel_o = 1'b1;
                alu_op_o  = ALU_ADD;
                imm_sel_o = IMM_MEM;
            end
            CLS_CBZ: begin
                br_zero_o = 1'b1;
                rd2_sel_o = 1'b1;
                alu_op_o  = ALU_PASS;
                imm_sel_o = IMM_CBR;
            end
            CLS_ADD: begin
                reg_wr_o = 1'b1;
                alu_op_o = ALU_ADD;
            end
            CLS_SUB: begin
                reg_wr_o = 1'b1;
                alu_op_o = ALU_SUB;
            end
            CLS_AND: begin
                reg_wr_o = 1'b1;
                alu_op_o = ALU_AND;
            end
            CLS_ORR: begin
                reg_wr_o = 1'b1;
                alu_op_o = ALU_OR;
            end
            CLS_MOVZ: begin
                alu_src_o = 1'b1;
                reg_wr_o  = 1'b1;
                alu_op_o  = ALU_PASS;
                imm_sel_o = IMM_WIDE;
            end
            CLS_BR: begin
                br_always_o = 1'b1;
                imm_sel_o   = IMM_JUMP;
            end
            CLS_NONE: begin
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
    import ctrl_dec_pkg::*;
#(
    parameter int OPC_W = OPC_BITS,
    parameter int ALU_W = ALU_BITS,
    parameter int IMM_W = IMM_BITS
) (
    input  logic [OPC_W-1:0] opc_i,
    output logic             alu_src_o,
    output logic             wb_from_mem_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             br_zero_o,
    output logic             br_always_o,
    output logic             reg_wr_o,
    output logic             rd2_sel_o,
    output logic [ALU_W-1:0] alu_op_o,
    output logic [IMM_W-1:0] imm_sel_o
);
    insn_cls_e cls;

    ctrl_classify #(.OPC_W(OPC_W)) classify_i (
        .opc_i (opc_i),
        .cls_o (cls)
    );

    ctrl_table #(.ALU_W(ALU_W), .IMM_W(IMM_W)) table_i (
        .cls_i         (cls),
        .alu_src_o     (alu_src_o),
        .wb_from_mem_o (wb_from_mem_o),
        .mem_rd_o      (mem_rd_o),
        .mem_wr_o      (mem_wr_o),
        .br_zero_o     (br_zero_o),
        .br_always_o   (br_always_o),
        .reg_wr_o      (reg_wr_o),
        .rd2_sel_o     (rd2_sel_o),
        .alu_op_o      (alu_op_o),
        .imm_sel_o     (imm_sel_o)
    );
endmodule

// File: rtl/ctrl_dec_chk.sv
module ctrl_dec_chk #(
    parameter int OPC_W = 11,
    parameter int ALU_W = 4,
    parameter int IMM_W = 3
) (
    input logic [OPC_W-1:0] opc_i,
    input logic             alu_src_o,
    input logic             wb_from_mem_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             br_zero_o,
    input logic             br_always_o,
    input logic             reg_wr_o,
    input logic             rd2_sel_o,
    input logic [ALU_W-1:0] alu_op_o,
    input logic [IMM_W-1:0] imm_sel_o
);
    logic known;
    always_comb begin
        known = (opc_i == 11'b11111000010) || (opc_i == 11'b11111000000) ||
                (opc_i == 11'b10110100000) || (opc_i == 11'b10001011000) ||
                (opc_i == 11'b11001011000) || (opc_i == 11'b10001010000) ||
                (opc_i == 11'b10101010000) ||
                (opc_i[OPC_W-1 -: 9] == 9'b110100101) ||
                (opc_i[OPC_W-1 -: 6] == 6'b000101);
    end

    always_comb begin
        // R9
        strobe_excl_chk: assert ($onehot0({mem_rd_o, mem_wr_o, br_zero_o, br_always_o}) &&
                                 (wb_from_mem_o == mem_rd_o))
            else $error("strobes overlap");
        // R1
        rd_only_load_chk: assert (!mem_rd_o || opc_i == 11'b11111000010)
            else $error("read strobe on non-load");
        // R2
        wr_only_store_chk: assert (!mem_wr_o || (opc_i == 11'b11111000000 && rd2_sel_o))
            else $error("write strobe on non-store");
        // R3
        cbz_pass_chk: assert (!br_zero_o || (opc_i == 11'b10110100000 && alu_op_o == 4'b0111 && imm_sel_o == 3'b101))
            else $error("conditional branch mismatch");
        // R7
        jump_prefix_chk: assert (!br_always_o || opc_i[OPC_W-1 -: 6] == 6'b000101)
            else $error("unconditional branch mismatch");
        // R8
        unknown_safe_chk: assert (known || !(reg_wr_o || mem_wr_o || mem_rd_o || br_zero_o || br_always_o))
            else $error("unknown opcode not safe");
        // R6
        movz_chk: assert (opc_i[OPC_W-1 -: 9] != 9'b110100101 || (reg_wr_o && alu_src_o && imm_sel_o == 3'b001))
            else $error("move-wide mismatch");
    end
endmodule

bind ctrl_decoder ctrl_dec_chk #(.OPC_W(OPC_W), .ALU_W(ALU_W), .IMM_W(IMM_W)) chk_i (
    .opc_i         (opc_i),
    .alu_src_o     (alu_src_o),
    .wb_from_mem_o (wb_from_mem_o),
    .mem_rd_o      (mem_rd_o),
    .mem_wr_o      (mem_wr_o),
    .br_zero_o     (br_zero_o),
    .br_always_o   (br_always_o),
    .reg_wr_o      (reg_wr_o),
    .rd2_sel_o     (rd2_sel_o),
    .alu_op_o      (alu_op_o),
    .imm_sel_o     (imm_sel_o)
);

// File: tb/ctrl_decoder_tb_top.sv
`timescale 1ns/1ps
module ctrl_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] opc = '0;
    logic        alu_src, wb_mem, mrd, mwr, bz, ba, rw, rsel;
    logic [3:0]  aop;
    logic [2:0]  isel;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    ctrl_decoder dut_i (
        .opc_i         (opc),
        .alu_src_o     (alu_src),
        .wb_from_mem_o (wb_mem),
        .mem_rd_o      (mrd),
        .mem_wr_o      (mwr),
        .br_zero_o     (bz),
        .br_always_o   (ba),
        .reg_wr_o      (rw),
        .rd2_sel_o     (rsel),
        .alu_op_o      (aop),
        .imm_sel_o     (isel)
    );

    // Expected {alu_src, wb_mem, mem_rd, mem_wr, br_zero, br_always, reg_wr, rd2_sel, alu_op, imm_sel}
    function automatic logic [14:0] model(input logic [10:0] o);
        logic [14:0] e;
        casez (o)
            11'b11111000010: e = {8'b11100010, 4'b0010, 3'b111};
            11'b11111000000: e = {8'b10010001, 4'b0010, 3'b111};
            11'b10110100000: e = {8'b00001001, 4'b0111, 3'b101};
            11'b10001011000: e = {8'b00000010, 4'b0010, 3'b000};
            11'b11001011000: e = {8'b00000010, 4'b0110, 3'b000};
            11'b10001010000: e = {8'b00000010, 4'b0000, 3'b000};
            11'b10101010000: e = {8'b00000010, 4'b0001, 3'b000};
            11'b110100101??: e = {8'b10000010, 4'b0111, 3'b001};
            11'b000101?????: e = {8'b00000100, 4'b0000, 3'b100};
            default:         e = '0;
        endcase
        return e;
    endfunction

    function automatic string req_of(input logic [10:0] o);
        casez (o)
            11'b11111000010: return "R1";
            11'b11111000000: return "R2";
            11'b10110100000: return "R3";
            11'b10001011000, 11'b11001011000: return "R4";
            11'b10001010000, 11'b10101010000: return "R5";
            11'b110100101??: return "R6";
            11'b000101?????: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [14:0] got, exp;
        got = {alu_src, wb_mem, mrd, mwr, bz, ba, rw, rsel, aop, isel};
        exp = model(opc);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s opc=%b actual=%b expected=%b", tag, opc, got, exp);
        end
        // R9: strobe exclusivity, checked at the ports
        n_chk++;
        if ($countones({mrd, mwr, bz, ba}) > 1 || wb_mem !== mrd) begin
            n_fail++;
            $display("FAIL R9 opc=%b actual=%b expected=at most one strobe", opc, {mrd, mwr, bz, ba});
        end
    endtask

    task automatic apply(input logic [10:0] v, input string tag);
        @(posedge clk);
        opc = v;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        opc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R8 reset");
        rst_n = 1'b1;
        apply(11'b11111000010, "R1 load");
        apply(11'b11111000000, "R2 store");
        apply(11'b10110100000, "R3 cbz");
        apply(11'b10001011000, "R4 add");
        apply(11'b11001011000, "R4 sub");
        apply(11'b10001010000, "R5 and");
        apply(11'b10101010000, "R5 orr");
        apply(11'b11010010100, "R6 movz lo00");
        apply(11'b11010010111, "R6 movz lo11");
        apply(11'b00010100000, "R7 jump lo00000");
        apply(11'b00010111111, "R7 jump lo11111");
        apply(11'b11111000011, "R8 near load");
        apply(11'b11111111111, "R8 all ones");
        apply(11'b11111000010, "R1 after unknown");
        for (int v = 0; v < 2048; v++) begin
            logic [10:0] o;
            o = 11'(v);
            apply(o, req_of(o));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule